// File: doc/BRIEF.md
# Fractional PLL Control Register Bank

This block holds the configuration of a fractional-N PLL behind a plain read/write strobe interface. It has four 32-bit registers, addressed by a 2-bit word index (register k sits at byte offset 4k). Each register drives a group of decoded PLL controls: the feedback divider, the reference divider, two post-dividers, a 24-bit fraction, a power-down bit and an integer/fractional mode select.

Three of the registers take per-bit write enables from the upper half-word of the write data. Software can therefore change one field without first reading the register back. The fraction register has no such enables: its low 24 bits are overwritten directly. Its top bit reads back the PLL lock indication. Reads are registered and return data in the cycle after the read strobe.

Top module: `pll_ctrl_regs`

## Requirements
- R1: After reset the feedback divider, reference divider and both post-dividers read 1, the fraction is 0, power-down is 1, integer mode is 1 and rdData is 0.
- R2: wordAddr selects the register: 0 holds the feedback divider, 1 the divider set, 2 the fraction, 3 the control bits. A write changes only the selected register.
- R3: For registers 0, 1 and 3, low bit i is loaded from wrData[i] only when wrData[i+16] is 1. Every other bit keeps its value.
- R4: Field layout. Register 0: feedback divider in bits 11:0. Register 1: reference divider in bits 5:0, post-divider 1 in bits 10:8, post-divider 2 in bits 14:12. Register 3: power-down in bit 0, integer mode in bit 3 (1 = integer, 0 = fractional).
- R5: A write to register 2 loads wrData[23:0] into the fraction unconditionally. wrData[31:24] has no effect on that register.
- R6: In the cycle after rdEn, rdData shows the addressed register. Bits outside defined fields read 0, including the whole upper half of registers 0, 1 and 3. Without rdEn, rdData holds its value.
- R7: Bit 31 of a register 2 read is the value of lockIn at the clock edge that takes the read. Bits 30:24 read 0.
- R8: pllEnabled is 1 exactly when power-down is 0.
- R9: Decoded outputs change in the cycle after the write edge, and only on a write.
- R10: A read and a write to the same register in one cycle return the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| wordAddr | input | 2 | Register index |
| wrData | input | 32 | Write data; upper half is the bit-enable mask for registers 0, 1, 3 |
| lockIn | input | 1 | Lock indication from the PLL |
| rdData | output | 32 | Registered read data |
| fbDiv | output | 12 | Feedback divider |
| refDiv | output | 6 | Reference divider |
| postDiv1 | output | 3 | First post-divider |
| postDiv2 | output | 3 | Second post-divider |
| fracVal | output | 24 | Fraction value |
| powerDown | output | 1 | PLL power-down |
| intMode | output | 1 | 1 selects integer mode, 0 fractional mode |
| pllEnabled | output | 1 | PLL enabled (power-down clear) |

## Verification
The assertions assume that the write strobe, read strobe, index and data are stable around each rising edge. They also assume lockIn is already synchronous to clk, so its sampled value is well defined at the read edge.

The bench changes every input only on the falling edge. It holds lockIn constant across each read edge. It mixes directed mask patterns with a long pseudo-random run of simultaneous read/write traffic, all inside that contract.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;
  localparam int DATA_W   = 32;
  localparam int HALF_W   = DATA_W / 2;
  localparam int NUM_REGS = 4;
  localparam int IDX_W    = $clog2(NUM_REGS);

  localparam int FB_W    = 12;
  localparam int REF_W   = 6;
  localparam int POST_W  = 3;
  localparam int FRAC_W  = 24;

  localparam int POST1_LSB = 8;
  localparam int POST2_LSB = 12;
  localparam int PD_BIT    = 0;
  localparam int INT_BIT   = 3;
  localparam int LOCK_BIT  = DATA_W - 1;

  localparam int FB_IDX   = 0;
  localparam int DIV_IDX  = 1;
  localparam int FRAC_IDX = 2;
  localparam int CTL_IDX  = 3;

  typedef logic [HALF_W-1:0] half_t;

  // Bits that exist in each masked register; all others read zero.
  localparam half_t IMPL_MASK [NUM_REGS] = '{
    half_t'((1 << FB_W) - 1),
    half_t'((((1 << POST_W) - 1) << POST2_LSB) | (((1 << POST_W) - 1) << POST1_LSB) | ((1 << REF_W) - 1)),
    half_t'(0),
    half_t'((1 << PD_BIT) | (1 << INT_BIT))
  };

  // Reset: every divider 1, powered down, integer mode.
  localparam half_t RST_LOW [NUM_REGS] = '{
    half_t'(1),
    half_t'((1 << POST2_LSB) | (1 << POST1_LSB) | 1),
    half_t'(0),
    half_t'((1 << PD_BIT) | (1 << INT_BIT))
  };

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    logic                rdStb;
    logic [IDX_W-1:0]    rdIdx;
  } pllStrobe_t;
endpackage

// File: rtl/pll_ctrl_decode.sv
module pll_ctrl_decode
  import pll_ctrl_pkg::*;
(
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [IDX_W-1:0] wordAddr,
  output pllStrobe_t       stb
);
  logic [NUM_REGS-1:0] sel;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign sel[r] = wrEn && (wordAddr == IDX_W'(r));
  end

  always_comb begin
    stb       = '0;
    stb.wrSel = sel;
    stb.rdStb = rdEn;
    stb.rdIdx = wordAddr;
  end
endmodule

// File: rtl/pll_ctrl_store.sv
module pll_ctrl_store
  import pll_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pllStrobe_t        stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lockIn,
  output logic [DATA_W-1:0] rdData,
  output logic [FB_W-1:0]   fbDiv,
  output logic [REF_W-1:0]  refDiv,
  output logic [POST_W-1:0] postDiv1,
  output logic [POST_W-1:0] postDiv2,
  output logic [FRAC_W-1:0] fracVal,
  output logic              powerDown,
  output logic              intMode
);
  half_t             lowVal   [NUM_REGS];
  logic [DATA_W-1:0] readView [NUM_REGS];
  logic [FRAC_W-1:0] fracReg;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    if (r == FRAC_IDX) begin : g_plain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              fracReg <= '0;
        else if (stb.wrSel[r])  fracReg <= wrData[FRAC_W-1:0];
      end
      logic [DATA_W-1:0] view;
      always_comb begin
        view                = '0;
        view[FRAC_W-1:0]    = fracReg;
        view[LOCK_BIT]      = lockIn;
      end
      assign lowVal[r]   = '0;
      assign readView[r] = view;
    end else begin : g_masked
      half_t store;
      half_t bitEn;
      assign bitEn = wrData[DATA_W-1:HALF_W] & IMPL_MASK[r];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             store <= RST_LOW[r];
        else if (stb.wrSel[r]) store <= (store & ~bitEn) | (wrData[HALF_W-1:0] & bitEn);
      end
      assign lowVal[r]   = store;
      assign readView[r] = {{(DATA_W-HALF_W){1'b0}}, store};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          rdData <= '0;
    else if (stb.rdStb) rdData <= readView[stb.rdIdx];
  end

  assign fbDiv     = lowVal[FB_IDX][FB_W-1:0];
  assign refDiv    = lowVal[DIV_IDX][REF_W-1:0];
  assign postDiv1  = lowVal[DIV_IDX][POST1_LSB +: POST_W];
  assign postDiv2  = lowVal[DIV_IDX][POST2_LSB +: POST_W];
  assign fracVal   = fracReg;
  assign powerDown = lowVal[CTL_IDX][PD_BIT];
  assign intMode   = lowVal[CTL_IDX][INT_BIT];

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrSel[FB_IDX] && wrData[HALF_W +: FB_W] == '0) |=> $stable(fbDiv)); // R3
  AST_FRAC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSel[FRAC_IDX] |=> (fracVal == $past(wrData[FRAC_W-1:0]))); // R5
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStb && stb.rdIdx != IDX_W'(FRAC_IDX)) |=> (rdData[DATA_W-1:HALF_W] == '0)); // R6
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdStb |=> $stable(rdData)); // R6
  AST_LOCK_READ: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdStb && stb.rdIdx == IDX_W'(FRAC_IDX)) |=> (rdData[LOCK_BIT] == $past(lockIn))); // R7
  AST_QUIET_CFG: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrSel == '0) |=> $stable({fbDiv, refDiv, postDiv1, postDiv2, fracVal, powerDown, intMode})); // R9
endmodule

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs
  import pll_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [IDX_W-1:0]  wordAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lockIn,
  output logic [DATA_W-1:0] rdData,
  output logic [FB_W-1:0]   fbDiv,
  output logic [REF_W-1:0]  refDiv,
  output logic [POST_W-1:0] postDiv1,
  output logic [POST_W-1:0] postDiv2,
  output logic [FRAC_W-1:0] fracVal,
  output logic              powerDown,
  output logic              intMode,
  output logic              pllEnabled
);
  pllStrobe_t stb;

  pll_ctrl_decode u_dec (
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .wordAddr (wordAddr),
    .stb      (stb)
  );

  pll_ctrl_store u_store (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .lockIn    (lockIn),
    .rdData    (rdData),
    .fbDiv     (fbDiv),
    .refDiv    (refDiv),
    .postDiv1  (postDiv1),
    .postDiv2  (postDiv2),
    .fracVal   (fracVal),
    .powerDown (powerDown),
    .intMode   (intMode)
  );

  assign pllEnabled = ~powerDown;

  AST_ENABLE_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    $fell(powerDown) |-> pllEnabled); // R8
  AST_CTL_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wordAddr == IDX_W'(CTL_IDX)) |=> $stable(powerDown)); // R2
endmodule

// File: tb/pll_ctrl_regs_bench.sv
module pll_ctrl_regs_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0, lockIn = 1'b0;
  logic [1:0]  wordAddr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [11:0] fbDiv;
  logic [5:0]  refDiv;
  logic [2:0]  postDiv1, postDiv2;
  logic [23:0] fracVal;
  logic        powerDown, intMode, pllEnabled;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model state
  logic [11:0] mFb;
  logic [5:0]  mRef;
  logic [2:0]  mP1, mP2;
  logic [23:0] mFrac;
  logic        mPd, mInt;
  logic [31:0] mRd;

  always #4 clk = ~clk;

  pll_ctrl_regs u_pll_ctrl_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wordAddr(wordAddr),
    .wrData(wrData), .lockIn(lockIn), .rdData(rdData), .fbDiv(fbDiv),
    .refDiv(refDiv), .postDiv1(postDiv1), .postDiv2(postDiv2),
    .fracVal(fracVal), .powerDown(powerDown), .intMode(intMode),
    .pllEnabled(pllEnabled)
  );

  function automatic logic [31:0] viewOf(logic [1:0] idx, logic lk);
    case (idx)
      2'd0:    return {20'b0, mFb};
      2'd1:    return {17'b0, mP2, 1'b0, mP1, 2'b0, mRef};
      2'd2:    return {lk, 7'b0, mFrac};
      default: return {28'b0, mInt, 2'b0, mPd};
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic compareAll(string tag);
    chk(tag, "fbDiv R4",      32'(fbDiv),      32'(mFb));
    chk(tag, "refDiv R4",     32'(refDiv),     32'(mRef));
    chk(tag, "postDiv1 R4",   32'(postDiv1),   32'(mP1));
    chk(tag, "postDiv2 R4",   32'(postDiv2),   32'(mP2));
    chk(tag, "fracVal R5",    32'(fracVal),    32'(mFrac));
    chk(tag, "powerDown R4",  32'(powerDown),  32'(mPd));
    chk(tag, "intMode R4",    32'(intMode),    32'(mInt));
    chk(tag, "pllEnabled R8", 32'(pllEnabled), 32'(!mPd));
    chk(tag, "rdData R6",     rdData,          mRd);
  endtask

  // One bus cycle: drive after the falling edge, model the rising edge,
  // compare at the next falling edge.
  task automatic step(string tag, logic we, logic re, logic [1:0] a, logic [31:0] d, logic lk);
    logic [31:0] nRd;
    wrEn = we; rdEn = re; wordAddr = a; wrData = d; lockIn = lk;
    nRd = re ? viewOf(a, lk) : mRd;
    @(posedge clk);
    mRd = nRd;
    if (we) begin
      case (a)
        2'd0: for (int i = 0; i < 12; i++) if (d[16+i]) mFb[i] = d[i];
        2'd1: begin
          for (int i = 0; i < 6; i++) if (d[16+i]) mRef[i] = d[i];
          for (int i = 0; i < 3; i++) begin
            if (d[24+i]) mP1[i] = d[8+i];
            if (d[28+i]) mP2[i] = d[12+i];
          end
        end
        2'd2: mFrac = d[23:0];
        default: begin
          if (d[16]) mPd = d[0];
          if (d[19]) mInt = d[3];
        end
      endcase
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R9 watchdog expired: got hang expected finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    mFb = 12'd1; mRef = 6'd1; mP1 = 3'd1; mP2 = 3'd1; mFrac = '0;
    mPd = 1'b1; mInt = 1'b1; mRd = '0;
    repeat (3) @(negedge clk);
    compareAll("R1 in reset");
    rstN = 1'b1;
    step("R1 after reset", 0, 0, 0, 32'h0, 0);

    // Full-mask writes
    step("R3 fb full mask",   1, 0, 0, 32'hFFFF_0ABC, 0);
    step("R3 fb zero mask",   1, 0, 0, 32'h0000_0123, 0);
    step("R3 fb partial",     1, 0, 0, 32'h000F_0FF5, 0);
    step("R4 div set",        1, 0, 1, 32'hFFFF_5A2C, 0);
    step("R3 only post2",     1, 0, 1, 32'h7000_3000, 0);
    step("R5 frac upper ign", 1, 0, 2, 32'hFF12_3456, 0);
    step("R8 power up",       1, 0, 3, 32'h0001_0000, 0);
    step("R4 frac mode",      1, 0, 3, 32'h0008_0000, 0);
    step("R3 ctl no mask",    1, 0, 3, 32'h0000_FFFF, 0);

    // Reads
    step("R6 read fb",        0, 1, 0, 32'hFFFF_FFFF, 0);
    step("R6 read div",       0, 1, 1, 32'h0, 0);
    step("R7 read frac lock", 0, 1, 2, 32'h0, 1);
    step("R7 read frac nolk", 0, 1, 2, 32'h0, 0);
    step("R6 read ctl",       0, 1, 3, 32'h0, 1);
    step("R6 rd hold",        0, 0, 0, 32'h0, 1);
    step("R9 idle",           0, 0, 3, 32'hFFFF_FFFF, 0);
    step("R10 rd+wr fb",      1, 1, 0, 32'hFFFF_0001, 0);
    step("R10 rd after",      0, 1, 0, 32'h0, 0);
    step("R2 wr div only",    1, 0, 1, 32'hFFFF_0000, 0);
    step("R2 readback",       0, 1, 1, 32'h0, 0);
    step("R8 power down",     1, 1, 3, 32'h0001_0001, 1);

    lfsr = 32'hACE1_2357;
    for (int n = 0; n < 400; n++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      step("R9 random", lfsr[0], lfsr[1], lfsr[3:2],
           {lfsr[31:20] ^ lfsr[11:0], lfsr[19:0]}, lfsr[4]);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule